// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the interrupt state of one processor across 256 vectors. Each vector has three bits: pending, in service, and a flag that records whether its last request was level-triggered. A request port sets the pending bit of one vector. A processor priority is formed from the task-priority value and the highest vector in service. Pending vectors compete against that priority by their 16-vector class, and the interrupt line goes high when the highest pending vector wins.

The processor answers with an acknowledge strobe. One cycle later the block returns a response. The response is either the winning vector, which then moves from pending to in service, or the spurious vector when the winner is blocked by priority, or a no-interrupt indication. An end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered and directed EOI is off, the block emits a one-cycle broadcast carrying the vector number, so that upstream level sources can be re-armed.

Top module: `vec_prio_core`

## Requirements
- R1: After reset, all pending, in-service and trigger bits and the task priority are clear. `irq_out`, `ack_done` and `bcast_valid` are low.
- R2: A request sets the pending bit of `req_vector` from the next cycle on. `req_level`=1 sets that vector's trigger bit and `req_level`=0 clears it. The trigger bit is observable only through the EOI broadcast.
- R3: When several vectors are pending, the acknowledged vector is the one with the highest number. This holds across every 32-bit word of the state.
- R4: The processor priority equals the task priority when its class (upper nibble) is greater than or equal to the class of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. `irq_out` is high only when software enable is set and a vector is pending, and either the processor priority is zero or the class of the highest pending vector is strictly greater than the class of the processor priority.
- R5: An acknowledge while `irq_out` is high returns `ack_kind`=2'b01 with the winning vector. That vector's pending bit clears and its in-service bit sets.
- R6: An acknowledge while a vector is pending but blocked by priority returns `ack_kind`=2'b10 with `ack_vector`=`spur_vec`, and no state changes.
- R7: An acknowledge with nothing pending, or while software enable is clear, returns `ack_kind`=2'b00 with `ack_vector`=0, and no state changes.
- R8: A task-priority write of the 4-bit value v sets the task priority to v·16. It takes effect from the next cycle.
- R9: An EOI clears the highest in-service bit. If that vector's trigger bit is set and `directed_eoi_en` is low, `bcast_valid` pulses for one cycle, one cycle after the strobe, with `bcast_vector` equal to that vector. Otherwise there is no broadcast.
- R10: While `sw_enable` is low, `irq_out` stays low and pending state is kept.
- R11: `ack_done` is high for exactly the one cycle that follows each cycle with `ack_req` high.
- R12: An EOI with nothing in service changes nothing and emits no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_done | output | 1 | Acknowledge response valid |
| ack_kind | output | 2 | 00 none, 01 vector, 10 spurious |
| ack_vector | output | 8 | Returned vector |
| eoi_strobe | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_val | input | 4 | Task-priority class to write |
| sw_enable | input | 1 | Software enable |
| spur_vec | input | 8 | Spurious vector value |
| directed_eoi_en | input | 1 | Suppresses the EOI broadcast |
| irq_out | output | 1 | Interrupt request to the processor |
| bcast_valid | output | 1 | EOI broadcast strobe |
| bcast_vector | output | 8 | Vector carried by the broadcast |

## Verification
The bench builds the block with its defaults: 256 vectors held in 32-bit words and 4-bit classes. This places vectors 0x00 and 0xFF at the two outer words of the scan. A single stimulus sequence can then cross word boundaries, reach the class extremes 0 and 15, and hit the equal-class blocking case at the boundary between a strict and a non-strict comparison. Task-priority values both above and below the in-service class exercise both branches of the processor-priority merge.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    typedef enum logic [1:0] {
        ACK_NONE = 2'b00,
        ACK_VEC  = 2'b01,
        ACK_SPUR = 2'b10
    } ack_kind_e;
endpackage

// File: rtl/vpc_scan.sv
// Finds the highest set bit of a wide vector, word by word.
module vpc_scan #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WB        = $clog2(WORD_W)
) (
    input  logic [NUM_VEC-1:0] bits,
    output logic               found,
    output logic [VEC_W-1:0]   top
);
    logic [NUM_WORDS-1:0]    w_any;
    logic [NUM_WORDS*WB-1:0] w_idx_flat;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WB-1:0] idx_l;
        always_comb begin
            idx_l = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) idx_l = WB'(b);
            end
        end
        assign w_any[w]                  = |bits[w*WORD_W +: WORD_W];
        assign w_idx_flat[w*WB +: WB]    = idx_l;
    end

    always_comb begin
        found = 1'b0;
        top   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (w_any[w]) begin
                found = 1'b1;
                top   = VEC_W'(w * WORD_W) | VEC_W'(w_idx_flat[w*WB +: WB]);
            end
        end
    end
endmodule

// File: rtl/vpc_dec.sv
// Index to one-hot mask.
module vpc_dec #(
    parameter int NUM_VEC = 256,
    localparam int VEC_W = $clog2(NUM_VEC)
) (
    input  logic [VEC_W-1:0]   idx,
    output logic [NUM_VEC-1:0] mask
);
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
        assign mask[i] = (idx == VEC_W'(i));
    end
endmodule

// File: rtl/vpc_prio.sv
// Processor priority merge and delivery decision.
module vpc_prio #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_top,
    output logic             deliver,
    output logic             blocked
);
    localparam int SUB_W = VEC_W - CLASS_W;

    logic [CLASS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;
    logic [VEC_W-1:0]   ppr;

    always_comb begin
        tpr_cls = tpr[VEC_W-1 -: CLASS_W];
        isr_cls = isr_top[VEC_W-1 -: CLASS_W];
        irr_cls = irr_top[VEC_W-1 -: CLASS_W];
        if (!isr_found || tpr_cls >= isr_cls) ppr = tpr;
        else                                  ppr = {isr_cls, {SUB_W{1'b0}}};
        ppr_cls = ppr[VEC_W-1 -: CLASS_W];
        deliver = irr_found && ((ppr == '0) || (irr_cls > ppr_cls));
        blocked = irr_found && !deliver;
    end
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int CLASS_W = 4,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int SUB_W  = VEC_W - CLASS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vector,
    input  logic               req_level,
    input  logic               ack_req,
    output logic               ack_done,
    output logic [1:0]         ack_kind,
    output logic [VEC_W-1:0]   ack_vector,
    input  logic               eoi_strobe,
    input  logic               tpr_wr,
    input  logic [CLASS_W-1:0] tpr_val,
    input  logic               sw_enable,
    input  logic [VEC_W-1:0]   spur_vec,
    input  logic               directed_eoi_en,
    output logic               irq_out,
    output logic               bcast_valid,
    output logic [VEC_W-1:0]   bcast_vector
);
    import vpc_pkg::*;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        logic               ack_done;
        ack_kind_e          ack_kind;
        logic [VEC_W-1:0]   ack_vec;
        logic               bc_valid;
        logic [VEC_W-1:0]   bc_vec;
    } state_t;

    state_t s_d, s_q;

    logic             irr_found, isr_found, deliver, blocked;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic [NUM_VEC-1:0] req_mask, ack_mask, eoi_mask;

    vpc_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_irr (
        .bits(s_q.irr), .found(irr_found), .top(irr_top));
    vpc_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_isr (
        .bits(s_q.isr), .found(isr_found), .top(isr_top));

    vpc_prio #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
        .tpr(s_q.tpr), .isr_found(isr_found), .isr_top(isr_top),
        .irr_found(irr_found), .irr_top(irr_top),
        .deliver(deliver), .blocked(blocked));

    vpc_dec #(.NUM_VEC(NUM_VEC)) u_dec_req (.idx(req_vector), .mask(req_mask));
    vpc_dec #(.NUM_VEC(NUM_VEC)) u_dec_ack (.idx(irr_top),    .mask(ack_mask));
    vpc_dec #(.NUM_VEC(NUM_VEC)) u_dec_eoi (.idx(isr_top),    .mask(eoi_mask));

    always_comb begin
        s_d          = s_q;
        s_d.ack_done = 1'b0;
        s_d.ack_kind = ACK_NONE;
        s_d.ack_vec  = '0;
        s_d.bc_valid = 1'b0;
        s_d.bc_vec   = '0;

        if (tpr_wr) s_d.tpr = {tpr_val, {SUB_W{1'b0}}};

        if (eoi_strobe && isr_found) begin
            s_d.isr = s_d.isr & ~eoi_mask;
            if (s_q.tmr[isr_top] && !directed_eoi_en) begin
                s_d.bc_valid = 1'b1;
                s_d.bc_vec   = isr_top;
            end
        end

        if (ack_req) begin
            s_d.ack_done = 1'b1;
            if (sw_enable && deliver) begin
                s_d.ack_kind = ACK_VEC;
                s_d.ack_vec  = irr_top;
                s_d.irr      = s_d.irr & ~ack_mask;
                s_d.isr      = s_d.isr | ack_mask;
            end else if (sw_enable && blocked) begin
                s_d.ack_kind = ACK_SPUR;
                s_d.ack_vec  = spur_vec;
            end
        end

        if (req_valid) begin
            s_d.irr = s_d.irr | req_mask;
            if (req_level) s_d.tmr = s_d.tmr | req_mask;
            else           s_d.tmr = s_d.tmr & ~req_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_out      = sw_enable && deliver;
    assign ack_done     = s_q.ack_done;
    assign ack_kind     = s_q.ack_kind;
    assign ack_vector   = s_q.ack_vec;
    assign bcast_valid  = s_q.bc_valid;
    assign bcast_vector = s_q.bc_vec;
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_req,
    input logic             ack_done,
    input logic [1:0]       ack_kind,
    input logic [VEC_W-1:0] ack_vector,
    input logic [VEC_W-1:0] spur_vec,
    input logic             irq_out,
    input logic             sw_enable,
    input logic             eoi_strobe,
    input logic             directed_eoi_en,
    input logic             bcast_valid
);
    p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_done);
    p_no_stray_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_done);
    p_vec_needs_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> (ack_kind != 2'b01) || $past(irq_out));
    p_spur_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> (ack_kind != 2'b10) || (ack_vector == $past(spur_vec) && !$past(irq_out)));
    p_disabled_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !sw_enable) |=> ack_kind == 2'b00);
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> sw_enable);
    p_bcast_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> $past(eoi_strobe) && !$past(directed_eoi_en));
    p_kind_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_kind) && (ack_done || ack_kind == 2'b00));
endmodule

bind vec_prio_core vpc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_done(ack_done),
    .ack_kind(ack_kind), .ack_vector(ack_vector), .spur_vec(spur_vec),
    .irq_out(irq_out), .sw_enable(sw_enable), .eoi_strobe(eoi_strobe),
    .directed_eoi_en(directed_eoi_en), .bcast_valid(bcast_valid));

// File: tb/sim_vec_prio_core.sv
`timescale 1ns/1ps
module sim_vec_prio_core;
    localparam logic [1:0] OP_REQ = 2'd0, OP_ACK = 2'd1, OP_EOI = 2'd2, OP_TPR = 2'd3;
    localparam logic [7:0] SPUR = 8'h1F;

    function automatic logic [22:0] mk(input logic [1:0] op, input logic [7:0] arg,
                                       input logic lvl, input logic irq,
                                       input logic [1:0] kind, input logic [7:0] val,
                                       input logic bc);
        return {op, arg, lvl, irq, kind, val, bc};
    endfunction

    localparam int NSTEP = 36;
    localparam logic [22:0] TBL [NSTEP] = '{
        mk(OP_REQ, 8'h45, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_REQ, 8'h92, 1'b1, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_REQ, 8'h31, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h92, 1'b0), // R3 highest across words
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b10, SPUR,  1'b0), // R6 blocked
        mk(OP_REQ, 8'hA0, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'hA0, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b1, 2'b00, 8'h92, 1'b1), // level -> broadcast
        mk(OP_TPR, 8'h05, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b10, SPUR,  1'b0), // R6 via task priority
        mk(OP_TPR, 8'h03, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h45, 1'b0),
        mk(OP_TPR, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h31, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0), // R7 nothing pending
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0), // R12 empty EOI
        mk(OP_REQ, 8'h4F, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h4F, 1'b0),
        mk(OP_REQ, 8'h41, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0), // equal class blocked
        mk(OP_EOI, 8'h00, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h41, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0),
        mk(OP_REQ, 8'h00, 1'b1, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_REQ, 8'hFF, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'hFF, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b10, SPUR,  1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h00, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b1), // vector 0 broadcast
        mk(OP_REQ, 8'h60, 1'b1, 1'b1, 2'b00, 8'h00, 1'b0),
        mk(OP_REQ, 8'h60, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0), // R2 edge clears trigger
        mk(OP_ACK, 8'h00, 1'b0, 1'b0, 2'b01, 8'h60, 1'b0),
        mk(OP_EOI, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0)
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_level = 0, ack_req = 0, eoi_strobe = 0, tpr_wr = 0;
    logic [7:0] req_vector = 0, spur_vec = SPUR;
    logic [3:0] tpr_val = 0;
    logic sw_enable = 1, directed_eoi_en = 0;
    logic ack_done, irq_out, bcast_valid;
    logic [1:0] ack_kind;
    logic [7:0] ack_vector, bcast_vector;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vec_prio_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_level(req_level), .ack_req(ack_req), .ack_done(ack_done),
        .ack_kind(ack_kind), .ack_vector(ack_vector), .eoi_strobe(eoi_strobe),
        .tpr_wr(tpr_wr), .tpr_val(tpr_val), .sw_enable(sw_enable),
        .spur_vec(spur_vec), .directed_eoi_en(directed_eoi_en), .irq_out(irq_out),
        .bcast_valid(bcast_valid), .bcast_vector(bcast_vector));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge with strobes cleared.
    task automatic do_op(input logic [1:0] op, input logic [7:0] arg, input logic lvl);
        req_valid  = (op == OP_REQ);
        req_vector = arg;
        req_level  = lvl;
        ack_req    = (op == OP_ACK);
        eoi_strobe = (op == OP_EOI);
        tpr_wr     = (op == OP_TPR);
        tpr_val    = arg[3:0];
        @(negedge clk);
        req_valid = 0; ack_req = 0; eoi_strobe = 0; tpr_wr = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_out, 0);
        check("R1 ack_done", ack_done, 0);
        check("R1 bcast", bcast_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after release", irq_out, 0);

        for (int i = 0; i < NSTEP; i++) begin
            logic [1:0] op;
            op = TBL[i][22:21];
            do_op(op, TBL[i][20:13], TBL[i][12]);
            check("R4 irq", irq_out, TBL[i][11]);
            case (op)
                OP_ACK: begin
                    check("R5 ack_done", ack_done, 1);
                    check("R5 ack_kind", ack_kind, TBL[i][10:9]);
                    check("R5 ack_vector", ack_vector, TBL[i][8:1]);
                end
                OP_EOI: begin
                    check("R9 bcast_valid", bcast_valid, TBL[i][0]);
                    if (TBL[i][0]) check("R9 bcast_vector", bcast_vector, TBL[i][8:1]);
                end
                OP_TPR:  check("R8 no response", ack_done | bcast_valid, 0);
                default: check("R2 no response", ack_done | bcast_valid, 0);
            endcase
        end

        // R10: disabled keeps pending state but holds irq low
        sw_enable = 0;
        do_op(OP_REQ, 8'h77, 1'b1);
        check("R10 irq disabled", irq_out, 0);
        do_op(OP_ACK, 8'h00, 1'b0);
        check("R7 disabled ack kind", ack_kind, 2'b00);
        check("R7 disabled ack vector", ack_vector, 0);
        sw_enable = 1;
        #1;
        check("R10 irq after enable", irq_out, 1);
        do_op(OP_ACK, 8'h00, 1'b0);
        check("R5 ack after enable", ack_vector, 8'h77);
        check("R5 kind after enable", ack_kind, 2'b01);
        @(negedge clk);
        check("R11 single-cycle ack_done", ack_done, 0);
        // R9: directed EOI suppresses the broadcast of a level vector
        directed_eoi_en = 1;
        do_op(OP_EOI, 8'h00, 1'b0);
        check("R9 directed no bcast", bcast_valid, 0);
        directed_eoi_en = 0;
        do_op(OP_EOI, 8'h00, 1'b0);
        check("R12 empty after directed", bcast_valid, 0);
        check("R4 idle irq", irq_out, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule